// File: doc/BRIEF.md
# SSI Absolute Position Reader

This block is the master side of a synchronous serial link to an absolute linear displacement sensor. The sensor's differential lines are converted to single-ended signals outside the block. On each request the block drives a clock that idles high. Its first falling edge tells the sensor to freeze its position. The block then clocks in a 25-bit straight-binary word, most significant bit first, and presents it on a parallel output with a one-cycle strobe.

A control loop raises `start` once per control period, typically every millisecond, on a 100 MHz system clock. The serial clock rate comes from a divider parameter. After every frame the clock stays high for a recovery interval so the sensor's internal timer can expire before the next read. Requests that arrive during a frame or during recovery are dropped.

Top module: `ssi_position_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, `ssi_clk` is high, `data_valid` is low; directly after reset `position` is zero.
- R2: A `start` high at a clock edge while idle drives `ssi_clk` low and `busy` high in the cycle that follows.
- R3: Within a frame `ssi_clk` changes level every `HALF_PERIOD` system cycles; a frame has exactly `POS_BITS`+1 falling and `POS_BITS`+1 rising edges.
- R4: `ssi_data` passes through two synchronizing flops and is sampled at every falling edge of `ssi_clk` except the first; the first sample is bit `POS_BITS`-1 of `position` (MSB first), with no Gray decoding.
- R5: `data_valid` is high for exactly one system cycle per frame, while `busy` is high and `ssi_clk` is low; `position` changes only in that cycle and holds its value otherwise.
- R6: After the final rising edge `ssi_clk` stays high; `busy` stays high for `RECOVERY_CYCLES` more cycles, so it is high for (2·`POS_BITS`+1)·`HALF_PERIOD`+`RECOVERY_CYCLES` cycles per frame.
- R7: `start` while `busy` is high, in the clocking or the recovery phase, has no effect: no extra clock edges, no change to the busy length, and no new frame afterwards.
- R8: Asserting `rst_n` low mid-frame returns `ssi_clk` high and `busy` and `data_valid` low at once, and the next frame after release reads correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted only while idle |
| ssi_data | input | 1 | Single-ended serial data from the sensor |
| ssi_clk | output | 1 | Serial clock to the sensor, idle high |
| position | output | POS_BITS | Last captured position word |
| data_valid | output | 1 | One-cycle strobe when `position` is updated |
| busy | output | 1 | High during a frame and its recovery interval |

## Verification
The bench keeps `POS_BITS` at 25 and builds the block with `HALF_PERIOD` of 3 and `RECOVERY_CYCLES` of 20. A whole frame then takes a few hundred cycles, so many patterns fit in one run. The short recovery interval means the bench can send start requests in its last cycles and during clocking, then count every edge of a frame exactly. Three cycles per half period is the smallest value at which a bit that changes just after a rising edge still passes the two-flop synchronizer before the next falling-edge sample.

// File: rtl/ssi_rd_pkg.sv
package ssi_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CLOCKING = 2'd1,
    ST_RECOVER  = 2'd2
  } ssi_state_e;
endpackage

// File: rtl/ssi_span_timer.sv
// Counts cycles while run is high; done flags the last cycle of the span.
module ssi_span_timer #(
  parameter int unsigned SPAN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (clear)      cnt_n = '0;
    else if (run)   cnt_n = done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ssi_word_shifter.sv
// Collects serial bits MSB first and publishes the word on the last one.
module ssi_word_shifter #(
  parameter int unsigned POS_BITS = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                last,
  input  logic                bit_in,
  output logic [POS_BITS-1:0] word,
  output logic                valid
);
  logic [POS_BITS-2:0] sh_q, sh_n;
  logic [POS_BITS-1:0] word_n;
  logic                valid_n;

  always_comb begin
    sh_n    = sh_q;
    word_n  = word;
    valid_n = 1'b0;
    if (shift_en) begin
      sh_n = {sh_q[POS_BITS-3:0], bit_in};
      if (last) begin
        word_n  = {sh_q, bit_in};
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      word  <= word_n;
      valid <= valid_n;
    end
  end
endmodule

// File: rtl/ssi_position_reader.sv
module ssi_position_reader #(
  parameter int unsigned POS_BITS        = 25,
  parameter int unsigned HALF_PERIOD     = 50,
  parameter int unsigned RECOVERY_CYCLES = 3000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ssi_data,
  output logic                ssi_clk,
  output logic [POS_BITS-1:0] position,
  output logic                data_valid,
  output logic                busy
);
  import ssi_rd_pkg::*;

  localparam int unsigned BW = $clog2(POS_BITS + 1);
  localparam logic [BW-1:0] ALL_BITS = BW'(POS_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(POS_BITS - 1);

  ssi_state_e    state_q, state_n;
  logic          clk_q, clk_n;
  logic [BW-1:0] bits_q, bits_n;
  logic [1:0]    sync_q;
  logic          half_tick, rec_done;
  logic          sample_en, sample_last;

  // two-flop synchronizer on the asynchronous sensor data line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ssi_data};
  end

  ssi_span_timer #(.SPAN(HALF_PERIOD)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(state_q != ST_CLOCKING),
    .run  (state_q == ST_CLOCKING),
    .done (half_tick)
  );

  ssi_span_timer #(.SPAN(RECOVERY_CYCLES)) u_recover (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(state_q != ST_RECOVER),
    .run  (state_q == ST_RECOVER),
    .done (rec_done)
  );

  always_comb begin
    state_n     = state_q;
    clk_n       = clk_q;
    bits_n      = bits_q;
    sample_en   = 1'b0;
    sample_last = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        clk_n = 1'b1;
        if (start) begin
          state_n = ST_CLOCKING;
          clk_n   = 1'b0;          // latch edge for the sensor
          bits_n  = '0;
        end
      end
      ST_CLOCKING: begin
        if (half_tick) begin
          clk_n = ~clk_q;
          if (clk_q) begin         // falling edge: take one bit
            sample_en   = 1'b1;
            sample_last = (bits_q == LAST_BIT);
            bits_n      = bits_q + 1'b1;
          end else if (bits_q == ALL_BITS) begin
            state_n = ST_RECOVER;  // final rising edge
          end
        end
      end
      ST_RECOVER: begin
        clk_n = 1'b1;
        if (rec_done) state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
        clk_n   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clk_q   <= 1'b1;
      bits_q  <= '0;
    end else begin
      state_q <= state_n;
      clk_q   <= clk_n;
      bits_q  <= bits_n;
    end
  end

  ssi_word_shifter #(.POS_BITS(POS_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sample_en),
    .last    (sample_last),
    .bit_in  (sync_q[1]),
    .word    (position),
    .valid   (data_valid)
  );

  assign ssi_clk = clk_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/ssi_position_reader_chk.sv
module ssi_position_reader_chk #(
  parameter int unsigned POS_BITS = 25
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ssi_clk,
  input logic [POS_BITS-1:0] position,
  input logic                data_valid,
  input logic                busy
);
  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ssi_clk && !data_valid));

  // R2
  start_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ssi_clk);

  // R3
  clk_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssi_clk) |-> busy);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(position));

  // R5
  valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (busy && !ssi_clk));
endmodule

bind ssi_position_reader ssi_position_reader_chk #(.POS_BITS(POS_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ssi_clk   (ssi_clk),
  .position  (position),
  .data_valid(data_valid),
  .busy      (busy)
);

// File: tb/ssi_position_reader_bench.sv
`timescale 1ns/1ps
module ssi_position_reader_bench;
  localparam int NB   = 25;
  localparam int HALF = 3;
  localparam int REC  = 20;
  localparam int BUSY_LEN = (2*NB + 1)*HALF + REC;
  localparam int NVEC = 8;

  localparam logic [NB-1:0] VEC_WORD [NVEC] = '{
    25'h0000000, 25'h1FFFFFF, 25'h1555555, 25'h0AAAAAA,
    25'h1000000, 25'h0000001, 25'h0123456, 25'h1C0FF3E };
  localparam bit VEC_POKE [NVEC] = '{0, 0, 1, 0, 1, 0, 0, 1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ssi_data = 1'b1;
  logic          ssi_clk;
  logic [NB-1:0] position;
  logic          data_valid;
  logic          busy;

  int checks = 0;
  int errors = 0;

  logic [NB-1:0] sens_word = '0;
  logic [NB-1:0] sens_sh = '0;
  int  sens_idx = 0;
  bit  in_frame = 1'b0;
  int  n_fall = 0;
  int  n_rise = 0;

  always #2 clk = ~clk;

  ssi_position_reader #(
    .POS_BITS(NB), .HALF_PERIOD(HALF), .RECOVERY_CYCLES(REC)
  ) u_ssi_position_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .ssi_data(ssi_data),
    .ssi_clk(ssi_clk), .position(position), .data_valid(data_valid), .busy(busy)
  );

  // sensor model: latch on first fall, shift MSB first on each rise
  always @(negedge ssi_clk) begin
    n_fall++;
    if (!in_frame) begin
      in_frame = 1'b1;
      sens_sh  = sens_word;
      sens_idx = 0;
    end
  end

  always @(posedge ssi_clk) begin
    if (in_frame) begin
      n_rise++;
      if (sens_idx < NB) ssi_data = sens_sh[NB-1-sens_idx];
      else begin
        ssi_data = 1'b1;
        in_frame = 1'b0;
      end
      sens_idx++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one full frame; optional start requests during clocking and recovery
  task automatic run_frame(input logic [NB-1:0] word, input bit poke);
    int cyc = 0;
    int vcnt = 0;
    logic [NB-1:0] cap = '0;
    sens_word = word;
    n_fall = 0;
    n_rise = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1 && ssi_clk === 1'b0, "R2", "busy/clk after start",
          {busy, ssi_clk}, 2'b10);
    while (busy === 1'b1 && cyc < 10000) begin
      cyc++;
      if (data_valid === 1'b1) begin
        vcnt++;
        cap = position;
      end
      start = poke && (cyc == 10 || cyc == BUSY_LEN - 1);
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == BUSY_LEN, "R6", "busy length", cyc, BUSY_LEN);
    check(vcnt == 1, "R5", "valid pulses", vcnt, 1);
    check(cap === word, "R4", "captured word", cap, word);
    check(n_fall == NB + 1 && n_rise == NB + 1, "R3", "edge counts",
          n_fall * 1000 + n_rise, (NB + 1) * 1000 + NB + 1);
    repeat (6) @(negedge clk);
    check(busy === 1'b0 && ssi_clk === 1'b1 && position === word, "R7",
          "idle after frame", {busy, ssi_clk}, 2'b01);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ssi_clk === 1'b1 && busy === 1'b0 && data_valid === 1'b0 && position === '0,
          "R1", "reset state", {ssi_clk, busy, data_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ssi_clk === 1'b1 && busy === 1'b0, "R1", "idle after release",
          {ssi_clk, busy}, 2'b10);

    for (int i = 0; i < NVEC; i++) run_frame(VEC_WORD[i], VEC_POKE[i]);

    // R3: half period length measured on one low phase
    begin
      int low = 0;
      sens_word = 25'h0F0F0F0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (ssi_clk === 1'b0 && low < 100) begin low++; @(negedge clk); end
      check(low == HALF, "R3", "low half period", low, HALF);
      while (busy === 1'b1) @(negedge clk);
      check(position === 25'h0F0F0F0, "R4", "word after timing frame",
            position, 25'h0F0F0F0);
    end

    // R8: reset in the middle of a frame
    sens_word = 25'h1234567;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ssi_clk === 1'b1 && busy === 1'b0 && data_valid === 1'b0 && position === '0,
          "R8", "abort by reset", {ssi_clk, busy, data_valid}, 3'b100);
    in_frame = 1'b0;
    ssi_data = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(25'h0BADCAF, 1'b0);
    check(position === 25'h0BADCAF, "R8", "frame after reset", position, 25'h0BADCAF);

    finish_run();
  end
endmodule